// File: doc/BRIEF.md
# Powerdown and Calibration Sequencer

This block is the control logic behind a slow, single-wire powerdown/calibrate input of a clock-recovery device. The wire is driven high to put the device to sleep. While it is high, the recovered clock and data drivers are held in their parked condition and the loss-of-lock alarm is kept quiet. When the wire is released, the sequencer first pulses an internal digital reset. It then launches a self-calibration if the preceding high time was long enough and a reference clock is present. After that it lets the lock-acquisition logic run.

The raw wire is brought into the system clock domain through a short flop chain. A saturating counter measures how long the synchronized level has been high. A falling edge is treated as a calibration request only when the high time reached the minimum, which is one microsecond at the default clock. If the reference is missing when the reset phase ends, the request is held in a waiting phase until the reference appears. A wire left undriven reads low, which means normal operation.

Top module: `pdcal_sequencer`

## Requirements
- R1: The raw input passes through a two-stage synchronizer. With the defaults, `out_park` is still low after the second rising edge following a rise of `pd_pin_raw`, and it is high after the third.
- R2: `out_park` and `alarm_hold` are both high exactly while the sequencer is powered down. They clear on the third rising edge after `pd_pin_raw` falls.
- R3: On every release from powerdown, `dig_rst` is high for exactly RST_CYCLES (default 8) clock cycles, starting with the cycle in which `out_park` clears.
- R4: A falling edge counts as a calibration request only if the synchronized input was high for at least CLK_FREQ_MHZ*MIN_HIGH_NS/1000 cycles (default 250). After a shorter high time, no `cal_start` is issued and `acq_en` rises directly after the reset phase.
- R5: `cal_start` is a one-cycle pulse. It is issued only when `ref_valid` was high on the deciding edge. With the reference present, it appears in the cycle right after the last `dig_rst` cycle.
- R6: If the reference is absent when the reset phase of a qualified release ends, the request is kept pending. During that wait, `cal_start`, `acq_en` and `out_park` all stay low. `cal_start` follows on the first edge that sees `ref_valid` high.
- R7: After `cal_start`, the sequencer waits for `cal_done`. `acq_en` rises on the edge that samples `cal_done` high. A `cal_done` outside the calibration phase has no effect.
- R8: A synchronized high level forces powerdown from any phase, including calibration and lock acquisition. It also discards any pending calibration request.
- R9: While `rst_n` is low, `dig_rst` is high and all other outputs are low. After release, `dig_rst` stays high until the RST_CYCLES-th rising edge. The sequencer then enters lock acquisition without a calibration.
- R10: The high-time counter saturates at its threshold. An arbitrarily long high time (e.g. 1000 cycles) still qualifies as a calibration request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_pin_raw | input | 1 | Asynchronous powerdown/calibrate wire, high = powerdown |
| ref_valid | input | 1 | Reference clock present, synchronous to clk |
| cal_done | input | 1 | Calibration complete strobe from the analog calibrator |
| cal_start | output | 1 | One-cycle pulse that launches a self-calibration |
| out_park | output | 1 | Holds clock and data drivers in their parked state |
| dig_rst | output | 1 | Reset for the downstream digital logic, active high |
| alarm_hold | output | 1 | Forces the loss-of-lock alarm low |
| acq_en | output | 1 | Enables lock acquisition on the data stream |

## Verification
The assertions assume that `ref_valid` and `cal_done` are already synchronous to `clk`. Only the powerdown wire is treated as asynchronous. They also assume that `cal_done` arrives as a strobe, not as a level, and that it comes only after a calibration has been launched. The stimulus changes every input on the falling clock edge. It keeps `cal_done` to single-cycle pulses, and the one `cal_done` issued outside calibration exists only to show that it is ignored. It drives high times of at least two cycles, so that the synchronized level is a clean pulse the bench can count.

// File: rtl/pdcal_pkg.sv
// Shared types for the powerdown/calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pdcal_pkg;

    // Sequencer phases; encoding is internal only
    typedef enum logic [2:0] {
        SEQ_PWRDN   = 3'd0,
        SEQ_RESET   = 3'd1,
        SEQ_WAITREF = 3'd2,
        SEQ_CAL     = 3'd3,
        SEQ_ACQ     = 3'd4
    } seq_state_t;

endpackage

// File: rtl/pdcal_sync.sv
// Multi-flop synchronizer for a slow asynchronous level.
// Assumes: the input changes far slower than clk; STAGES >= 2.
module pdcal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain, cleared to "not powered down"
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/pdcal_hightimer.sv
// Measures how long the synchronized input has been high, saturating at
// THRESH. long_enough is valid in the first low cycle after a high run,
// which is the cycle in which the sequencer sees the falling edge.
// Assumes: level is already synchronous to clk.
module pdcal_hightimer #(
    parameter int THRESH = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic long_enough
);

    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] hi_cnt;

    // Count high cycles, stop at the limit, clear on any low cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_cnt <= '0;
        else if (!level)     hi_cnt <= '0;
        else if (hi_cnt != LIMIT) hi_cnt <= hi_cnt + CW'(1);
    end

    assign long_enough = (hi_cnt == LIMIT);

    // R10: the counter never runs past its threshold
    a_r10_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= LIMIT);

    // R10: once saturated, a continued high level keeps it saturated
    a_r10_sat_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (long_enough && level) |=> long_enough);

endmodule

// File: rtl/pdcal_fsm.sv
// Phase controller: powerdown, digital reset, wait for reference,
// calibration, lock acquisition. Drives all block outputs from its state.
// Assumes: pin_s is synchronized; ref_valid and cal_done are synchronous
// to clk; long_enough is valid in the first cycle pin_s is low.
module pdcal_fsm
    import pdcal_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic long_enough,
    input  logic ref_valid,
    input  logic cal_done,
    output logic cal_start,
    output logic out_park,
    output logic dig_rst,
    output logic alarm_hold,
    output logic acq_en
);

    localparam int RCW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [RCW-1:0] RST_LAST = RCW'(RST_CYCLES - 1);

    seq_state_t     state, nxt;
    logic [RCW-1:0] rst_cnt;
    logic           cal_req;

    // Next-phase selection; a high input overrides every phase
    always_comb begin
        nxt = state;
        if (pin_s) begin
            nxt = SEQ_PWRDN;
        end else begin
            case (state)
                SEQ_PWRDN:   nxt = SEQ_RESET;
                SEQ_RESET:   if (rst_cnt == RST_LAST)
                                 nxt = !cal_req   ? SEQ_ACQ :
                                       ref_valid  ? SEQ_CAL : SEQ_WAITREF;
                SEQ_WAITREF: if (ref_valid) nxt = SEQ_CAL;
                SEQ_CAL:     if (cal_done)  nxt = SEQ_ACQ;
                SEQ_ACQ:     nxt = SEQ_ACQ;
                default:     nxt = SEQ_RESET;
            endcase
        end
    end

    // Phase register; reset lands in the digital-reset phase
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_RESET;
        else        state <= nxt;
    end

    // Length counter for the digital-reset phase
    always_ff @(posedge clk) begin
        if (!rst_n)                                 rst_cnt <= '0;
        else if (state == SEQ_RESET && nxt == SEQ_RESET) rst_cnt <= rst_cnt + RCW'(1);
        else                                        rst_cnt <= '0;
    end

    // Calibration request latched at release, dropped on launch or powerdown
    always_ff @(posedge clk) begin
        if (!rst_n)                                       cal_req <= 1'b0;
        else if (state == SEQ_PWRDN && nxt == SEQ_RESET)  cal_req <= long_enough;
        else if (nxt == SEQ_CAL || nxt == SEQ_PWRDN)      cal_req <= 1'b0;
    end

    // One-cycle launch pulse on entry to calibration
    always_ff @(posedge clk) begin
        if (!rst_n) cal_start <= 1'b0;
        else        cal_start <= (nxt == SEQ_CAL) && (state != SEQ_CAL);
    end

    assign out_park   = (state == SEQ_PWRDN);
    assign alarm_hold = (state == SEQ_PWRDN);
    assign dig_rst    = (state == SEQ_RESET);
    assign acq_en     = (state == SEQ_ACQ);

    // R8: a synchronized high level parks the outputs on the next edge
    a_r8_high_parks: assert property (@(posedge clk) disable iff (!rst_n)
        pin_s |=> out_park);

    // R5: a launch only happens with the reference seen on the deciding edge
    a_r5_start_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> $past(ref_valid));

    // R5: the launch is a single-cycle pulse
    a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R7: lock acquisition is left only for powerdown
    a_r7_acq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_en && !pin_s) |=> acq_en);

    // R3: the reset-phase counter stays inside its window
    a_r3_rst_window: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cnt <= RST_LAST);

    // R6: waiting without a reference produces no launch
    a_r6_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WAITREF && !ref_valid && !pin_s) |=> (!cal_start && !acq_en));

endmodule

// File: rtl/pdcal_sequencer.sv
// Top of the powerdown/calibration sequencer: synchronizes the wire,
// times its high level and runs the phase controller.
// Assumes: clk frequency equals CLK_FREQ_MHZ; ref_valid and cal_done are
// synchronous to clk; pd_pin_raw is asynchronous.
module pdcal_sequencer #(
    parameter int CLK_FREQ_MHZ = 250,
    parameter int MIN_HIGH_NS  = 1000,
    parameter int RST_CYCLES   = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_pin_raw,
    input  logic ref_valid,
    input  logic cal_done,
    output logic cal_start,
    output logic out_park,
    output logic dig_rst,
    output logic alarm_hold,
    output logic acq_en
);

    localparam int MIN_HIGH_CYC = (CLK_FREQ_MHZ * MIN_HIGH_NS) / 1000;

    logic pin_s;
    logic long_enough;

    pdcal_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pd_pin_raw),
        .q_out (pin_s)
    );

    pdcal_hightimer #(
        .THRESH (MIN_HIGH_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (pin_s),
        .long_enough (long_enough)
    );

    pdcal_fsm #(
        .RST_CYCLES (RST_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_s       (pin_s),
        .long_enough (long_enough),
        .ref_valid   (ref_valid),
        .cal_done    (cal_done),
        .cal_start   (cal_start),
        .out_park    (out_park),
        .dig_rst     (dig_rst),
        .alarm_hold  (alarm_hold),
        .acq_en      (acq_en)
    );

endmodule

// File: tb/pdcal_sequencer_bench.sv
`timescale 1ns/1ps
module pdcal_sequencer_bench;

    localparam int RSTC = 8;
    localparam int NVEC = 6;
    // high time in cycles, and whether a calibration launch is expected
    localparam int VEC_HIGH [NVEC] = '{2, 20, 249, 250, 251, 1000};
    localparam int VEC_CAL  [NVEC] = '{0, 0,  0,   1,   1,   1};

    logic clk = 1'b0;
    logic rst_n, pd_pin_raw, ref_valid, cal_done;
    logic cal_start, out_park, dig_rst, alarm_hold, acq_en;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    pdcal_sequencer u_pdcal_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_pin_raw (pd_pin_raw),
        .ref_valid  (ref_valid),
        .cal_done   (cal_done),
        .cal_start  (cal_start),
        .out_park   (out_park),
        .dig_rst    (dig_rst),
        .alarm_hold (alarm_hold),
        .acq_en     (acq_en)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Hold the wire high for n cycles, checking the park latency (R1, R2)
    task automatic drive_high(int n);
        @(negedge clk);
        pd_pin_raw = 1'b1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == 2) chk("R1", "park before third edge", int'(out_park), 0);
            if (k == 3) begin
                chk("R1", "park after third edge", int'(out_park), 1);
                chk("R2", "alarm hold while parked", int'(alarm_hold), 1);
                chk("R8", "no acquisition while parked", int'(acq_en), 0);
            end
        end
        pd_pin_raw = 1'b0;
    endtask

    // Walk the release; mode 0 = no launch, 1 = launch, 2 = pending
    task automatic release_check(int mode);
        for (int i = 1; i <= RSTC + 3; i++) begin
            @(negedge clk);
            if (i <= 2) begin
                chk("R2", "still parked after fall", int'(out_park), 1);
                chk("R2", "alarm still held", int'(alarm_hold), 1);
            end else if (i <= RSTC + 2) begin
                chk("R3", "digital reset phase", int'(dig_rst), 1);
                chk("R2", "park released", int'(out_park), 0);
                chk("R2", "alarm released", int'(alarm_hold), 0);
                chk("R5", "no launch during reset", int'(cal_start), 0);
            end else begin
                chk("R3", "reset phase ended", int'(dig_rst), 0);
                if (mode == 1) begin
                    chk("R5", "launch after reset", int'(cal_start), 1);
                    chk("R4", "no acquisition yet", int'(acq_en), 0);
                end else if (mode == 0) begin
                    chk("R4", "no launch for short high", int'(cal_start), 0);
                    chk("R4", "acquisition after reset", int'(acq_en), 1);
                end else begin
                    chk("R6", "no launch without reference", int'(cal_start), 0);
                    chk("R6", "no acquisition while pending", int'(acq_en), 0);
                end
            end
        end
    endtask

    // Finish a launched calibration (R5 single pulse, R7 completion)
    task automatic finish_cal();
        @(negedge clk);
        chk("R5", "launch is one cycle", int'(cal_start), 0);
        chk("R7", "waiting for done", int'(acq_en), 0);
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
        chk("R7", "acquisition after done", int'(acq_en), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pd_pin_raw = 1'b0; ref_valid = 1'b1; cal_done = 1'b0;
        repeat (3) @(negedge clk);
        // R9: state while in reset
        chk("R9", "dig_rst in reset", int'(dig_rst), 1);
        chk("R9", "park in reset", int'(out_park), 0);
        chk("R9", "alarm hold in reset", int'(alarm_hold), 0);
        chk("R9", "cal_start in reset", int'(cal_start), 0);
        chk("R9", "acq_en in reset", int'(acq_en), 0);
        rst_n = 1'b1;
        for (int i = 1; i <= RSTC; i++) begin
            @(negedge clk);
            if (i < RSTC) chk("R9", "dig_rst after release", int'(dig_rst), 1);
            else begin
                chk("R9", "dig_rst ends", int'(dig_rst), 0);
                chk("R9", "acquisition without calibration", int'(acq_en), 1);
                chk("R9", "no launch after reset", int'(cal_start), 0);
            end
        end

        // Vector table: high time versus launch (R4, R10 at 1000 cycles)
        for (int v = 0; v < NVEC; v++) begin
            drive_high(VEC_HIGH[v]);
            release_check(VEC_CAL[v]);
            if (VEC_CAL[v] != 0) finish_cal();
            repeat (3) @(negedge clk);
        end

        // R6: qualified release with no reference waits, ignores cal_done (R7)
        ref_valid = 1'b0;
        drive_high(300);
        release_check(2);
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            cal_done = (i == 4);
            chk("R6", "pending: no launch", int'(cal_start), 0);
            chk("R7", "pending: stray done ignored", int'(acq_en), 0);
            chk("R6", "pending: not parked", int'(out_park), 0);
        end
        cal_done = 1'b0;
        ref_valid = 1'b1;
        @(negedge clk);
        chk("R6", "launch once reference arrives", int'(cal_start), 1);
        finish_cal();

        // R4: short high with no reference goes straight to acquisition
        ref_valid = 1'b0;
        drive_high(100);
        release_check(0);
        ref_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5", "reference alone launches nothing", int'(cal_start), 0);
        chk("R4", "still acquiring", int'(acq_en), 1);

        // R8: powerdown during calibration aborts it
        drive_high(260);
        release_check(1);
        drive_high(5);
        release_check(0);

        // R7: cal_done during acquisition has no effect
        @(negedge clk);
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
        chk("R7", "done in acquisition ignored", int'(acq_en), 1);
        chk("R7", "no launch from stray done", int'(cal_start), 0);
        @(negedge clk);
        chk("R7", "acquisition holds", int'(acq_en), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule